// File: doc/BRIEF.md
# Timer Input Capture with Atomic Byte Access

This block pairs a free-running 16-bit counter with a capture register that takes a snapshot of the counter when a selected edge arrives on an external capture pin. When a capture happens, a status flag is raised. Software can clear the flag. All 16-bit quantities are reached over an 8-bit register bus. The counter, the capture register and two compare registers are all 16 bits wide.

One holding byte is shared by every 16-bit register so that a value can be read or written coherently in two byte accesses. To read, software fetches the low byte first, which parks the matching high byte in the holding byte. To write, software stores the high byte first, and the low-byte write then commits all sixteen bits in one clock. The compare registers are only stored here. Their values drive output ports for the neighbouring compare logic.

The capture pin is asynchronous. It passes through a two-flop synchronizer before the edge detector compares consecutive samples.

Top module: `icap_unit`

## Requirements
- R1: After reset the capture register, the compare registers, the holding byte and the flag read 0, and the edge-select bit reads 1.
- R2: The counter advances by one every clock. A low-byte write to the counter loads {holding byte, written byte}, and counting resumes from that value on the next clock.
- R3: The capture pin is synchronized through two flops. If the pin changes just after clock edge E, the capture register takes the counter value present between edges E+2 and E+3, which is V+2 when the counter was loaded with V at edge E.
- R4: Control bit 0 selects the capture edge, with 1 meaning rising and 0 meaning falling. An edge of the other polarity changes neither the flag nor the capture register.
- R5: The flag (status bit 0) is set on the same clock edge that loads the capture register.
- R6: Writing status with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: When a capture and a flag-clear write land on the same clock edge, the flag ends up set.
- R8: A low-byte read returns that register's live low byte and copies its high byte into the holding byte. A high-byte read returns the holding byte.
- R9: Every 16-bit register shares the one holding byte. A high-byte read returns whatever the most recent low-byte read or high-byte write placed there.
- R10: A compare high-byte write changes only the holding byte, so the compare output is unchanged. The following low-byte write updates the compare output to all 16 bits at once.
- R11: Writes to either capture address are ignored. Neither the capture register nor the holding byte changes.
- R12: Address map: 0/1 counter low/high, 2/3 capture low/high, 4/5 compare A low/high, 6/7 compare B low/high, 8 control, 9 status. Unused bits and addresses read 0. Read data is valid while the read strobe is high.

Only the top module has ports. The submodules connect internally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_in | input | 1 | Asynchronous capture pin |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe; side effects act at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| cmp_a | output | 16 | Compare A value |
| cmp_b | output | 16 | Compare B value |

## Verification
A corrupted holding byte shows up on the very next high-byte read as a value that belongs to another register or to a newer counter value. The bench provokes this by letting the counter carry into its high byte between the two reads. A synchronizer depth or capture alignment that is off by one cycle changes the captured counter value by exactly one, and this is visible on the first read of the capture register after the capture. Wrong flag priority or clear handling appears in the status read that follows the write.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO  = 4'h0,
    A_CNT_HI  = 4'h1,
    A_CAP_LO  = 4'h2,
    A_CAP_HI  = 4'h3,
    A_CMPA_LO = 4'h4,
    A_CMPA_HI = 4'h5,
    A_CMPB_LO = 4'h6,
    A_CMPB_HI = 4'h7,
    A_CTRL    = 4'h8,
    A_STAT    = 4'h9
  } reg_addr_e;
endpackage

// File: rtl/icap_edge_detect.sv
module icap_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sel_rise,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  always_comb begin
    if (sel_rise) edge_hit = sync_q[SYNC_STAGES-1] & ~prev_q;
    else          edge_hit = ~sync_q[SYNC_STAGES-1] & prev_q;
  end

  // R3: one edge yields a single-cycle detection unless the polarity changes
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (!edge_hit || !$stable(sel_rise)));
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: without a load the counter advances by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/icap_regbank.sv
module icap_regbank
  import icap_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [WORD_W-1:0] cnt,
  output logic              cnt_load,
  output logic [WORD_W-1:0] cnt_load_val,
  input  logic              cap_hit,
  output logic              sel_rise,
  output logic [WORD_W-1:0] cmp_a,
  output logic [WORD_W-1:0] cmp_b
);
  logic [BYTE_W-1:0] temp_q, temp_d;
  logic [WORD_W-1:0] cap_q, cap_d;
  logic [WORD_W-1:0] cmpa_q, cmpa_d;
  logic [WORD_W-1:0] cmpb_q, cmpb_d;
  logic              flag_q, flag_d;
  logic              rise_q, rise_d;

  always_comb begin
    temp_d       = temp_q;
    cap_d        = cap_q;
    cmpa_d       = cmpa_q;
    cmpb_d       = cmpb_q;
    flag_d       = flag_q;
    rise_d       = rise_q;
    cnt_load     = 1'b0;
    cnt_load_val = {temp_q, wdata};
    if (rd_en) begin
      case (addr)
        A_CNT_LO:  temp_d = cnt[WORD_W-1:BYTE_W];
        A_CAP_LO:  temp_d = cap_q[WORD_W-1:BYTE_W];
        A_CMPA_LO: temp_d = cmpa_q[WORD_W-1:BYTE_W];
        A_CMPB_LO: temp_d = cmpb_q[WORD_W-1:BYTE_W];
        default:   ;
      endcase
    end
    if (wr_en) begin
      case (addr)
        A_CNT_HI, A_CMPA_HI, A_CMPB_HI: temp_d = wdata;
        A_CNT_LO:  cnt_load = 1'b1;
        A_CMPA_LO: cmpa_d = {temp_q, wdata};
        A_CMPB_LO: cmpb_d = {temp_q, wdata};
        A_CTRL:    rise_d = wdata[0];
        A_STAT:    if (wdata[0]) flag_d = 1'b0;
        default:   ;
      endcase
    end
    if (cap_hit) begin
      cap_d  = cnt;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      cap_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      flag_q <= 1'b0;
      rise_q <= 1'b1;
    end else begin
      temp_q <= temp_d;
      cap_q  <= cap_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      flag_q <= flag_d;
      rise_q <= rise_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CNT_LO:  rdata = cnt[BYTE_W-1:0];
        A_CAP_LO:  rdata = cap_q[BYTE_W-1:0];
        A_CMPA_LO: rdata = cmpa_q[BYTE_W-1:0];
        A_CMPB_LO: rdata = cmpb_q[BYTE_W-1:0];
        A_CNT_HI, A_CAP_HI, A_CMPA_HI, A_CMPB_HI: rdata = temp_q;
        A_CTRL:    rdata = {{(BYTE_W-1){1'b0}}, rise_q};
        A_STAT:    rdata = {{(BYTE_W-1){1'b0}}, flag_q};
        default:   rdata = '0;
      endcase
    end
  end

  assign sel_rise = rise_q;
  assign cmp_a    = cmpa_q;
  assign cmp_b    = cmpb_q;

  // R3: the capture register receives the counter value of the detection cycle
  p_capture_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> cap_q == $past(cnt));
  // R5: the flag is set together with the capture load
  p_flag_with_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> flag_q);
  // R6: clearing without a capture drops the flag
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wdata[0] && !cap_hit) |=> !flag_q);
  // R11: capture addresses are read-only
  p_cap_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_CAP_LO || addr == A_CAP_HI) && !cap_hit) |=> $stable(cap_q));
  // R10: a high-byte write never moves a compare register
  p_hi_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_CMPA_HI || addr == A_CMPB_HI)) |=> ($stable(cmpa_q) && $stable(cmpb_q)));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] cmp_a,
  output logic [WORD_W-1:0] cmp_b
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic [WORD_W-1:0] cnt;
  logic              cnt_load;
  logic [WORD_W-1:0] cnt_load_val;
  logic              cap_hit;
  logic              sel_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  icap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_i),
    .pin      (cap_in),
    .sel_rise (sel_rise),
    .edge_hit (cap_hit)
  );

  icap_counter #(.CNT_W(WORD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .cnt      (cnt)
  );

  icap_regbank #(.BYTE_W(BYTE_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_i),
    .addr         (bus_addr),
    .wr_en        (bus_wr),
    .rd_en        (bus_rd),
    .wdata        (bus_wdata),
    .rdata        (bus_rdata),
    .cnt          (cnt),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cap_hit      (cap_hit),
    .sel_rise     (sel_rise),
    .cmp_a        (cmp_a),
    .cmp_b        (cmp_b)
  );
endmodule

// File: tb/icap_unit_test.sv
module icap_unit_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] CNT_LO = 4'h0, CNT_HI = 4'h1, CAP_LO = 4'h2, CAP_HI = 4'h3,
                         CMPA_LO = 4'h4, CMPA_HI = 4'h5, CMPB_LO = 4'h6, CMPB_HI = 4'h7,
                         CTRL = 4'h8, STAT = 4'h9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_in;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] cmp_a;
  logic [15:0] cmp_b;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t exp_q[$];
  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icap_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_in    (cap_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b)
  );

  // monitor: compares read data mid-cycle against the queued expectation
  always @(negedge clk) begin
    if (bus_rd) begin
      exp_item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: read with no expectation, actual=%02h", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic chk16(input logic [15:0] act, input logic [15:0] e, input string tag);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=%04h expected=%04h", tag, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cap_in = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    // R1: reset state
    bus_read(CAP_LO, 8'h00, "R1 capture low");
    bus_read(CAP_HI, 8'h00, "R1 capture high / holding byte");
    bus_read(STAT,   8'h00, "R1 flag");
    bus_read(CTRL,   8'h01, "R1 edge select");
    chk16(cmp_a, 16'h0000, "R1 cmp_a");
    chk16(cmp_b, 16'h0000, "R1 cmp_b");

    // R2 / R8: counter load, atomic read across a carry
    bus_write(CNT_HI, 8'h12);
    bus_write(CNT_LO, 8'hFE);
    bus_read(CNT_LO, 8'hFE, "R8 counter low read");
    idle(3);
    bus_read(CNT_HI, 8'h12, "R8 high read returns latched byte");
    bus_read(CNT_LO, 8'h03, "R2 counter advanced");
    bus_read(CNT_HI, 8'h13, "R2 counter high after carry");

    // R3 / R5: rising capture
    bus_write(CNT_HI, 8'h40);
    bus_write(CNT_LO, 8'h10);
    cap_in = 1'b1;
    idle(6);
    bus_read(STAT,   8'h01, "R5 flag after capture");
    bus_read(CAP_LO, 8'h12, "R3 capture low");
    bus_read(CAP_HI, 8'h40, "R3 capture high");

    // R9: shared holding byte
    bus_read(CAP_LO,  8'h12, "R9 capture low again");
    bus_read(CMPB_HI, 8'h40, "R9 other register high returns shared byte");

    // R11: capture addresses are read-only
    bus_write(CAP_LO, 8'h55);
    bus_write(CAP_HI, 8'h66);
    bus_read(CMPA_HI, 8'h40, "R11 holding byte untouched");
    bus_read(CAP_LO,  8'h12, "R11 capture low unchanged");
    bus_read(CAP_HI,  8'h40, "R11 capture high unchanged");

    // R6: flag clear semantics
    bus_write(STAT, 8'h00);
    bus_read(STAT, 8'h01, "R6 write 0 keeps flag");
    bus_write(STAT, 8'h01);
    bus_read(STAT, 8'h00, "R6 write 1 clears flag");

    // R4: falling edge ignored while rising selected
    cap_in = 1'b0;
    idle(6);
    bus_read(STAT,   8'h00, "R4 wrong edge no flag");
    bus_read(CAP_LO, 8'h12, "R4 wrong edge no capture");

    // R4: falling select
    bus_write(CTRL, 8'h00);
    bus_read(CTRL, 8'h00, "R4 edge select readback");
    cap_in = 1'b1;
    idle(6);
    bus_read(STAT, 8'h00, "R4 rising ignored under falling select");
    bus_write(CNT_HI, 8'h7F);
    bus_write(CNT_LO, 8'h00);
    cap_in = 1'b0;
    idle(6);
    bus_read(STAT,   8'h01, "R4 falling capture flag");
    bus_read(CAP_LO, 8'h02, "R4 falling capture low");
    bus_read(CAP_HI, 8'h7F, "R4 falling capture high");

    // R7: capture and clear on the same edge
    bus_write(STAT, 8'h01);
    bus_read(STAT, 8'h00, "R7 flag cleared before race");
    bus_write(CTRL, 8'h01);
    bus_write(CNT_HI, 8'hA0);
    bus_write(CNT_LO, 8'hA0);
    cap_in = 1'b1;
    step();
    step();
    bus_write(STAT, 8'h01);
    bus_read(STAT,   8'h01, "R7 capture wins over clear");
    bus_read(CAP_LO, 8'hA2, "R7 capture low");
    bus_read(CAP_HI, 8'hA0, "R7 capture high");

    // R10: compare registers
    bus_write(CMPA_HI, 8'hAB);
    chk16(cmp_a, 16'h0000, "R10 high write alone no commit");
    bus_write(CMPA_LO, 8'hCD);
    chk16(cmp_a, 16'hABCD, "R10 low write commits");
    bus_read(CMPA_LO, 8'hCD, "R10 compare A low");
    bus_read(CMPA_HI, 8'hAB, "R10 compare A high");
    bus_write(CMPB_HI, 8'h5A);
    bus_write(CMPB_LO, 8'hC3);
    chk16(cmp_b, 16'h5AC3, "R10 cmp_b commit");
    chk16(cmp_a, 16'hABCD, "R10 cmp_a undisturbed");

    // R9 / R12: high read after a high write returns the written byte; unused address
    bus_write(CNT_HI, 8'h77);
    bus_read(CAP_HI, 8'h77, "R9 high read after high write");
    bus_read(4'hF,   8'h00, "R12 unused address reads 0");

    idle(2);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule